// File: doc/BRIEF.md
# Parallel Slave Port Controller

This block turns an 8-bit data port into a slave that an external host can read and write without sharing the local clock. The host qualifies each access with an active-low select and uses separate active-low read and write strobes. The local CPU sees two locations: a data location and a control/status location. Host writes fill an input buffer that the CPU reads. CPU writes fill an output buffer that the host reads.

A mode bit in the control location enables the slave function. While the mode bit is clear, the host pins have no effect on any state, and the remaining control bits act as three general-purpose direction bits. The strobe and select inputs pass through a multi-stage synchronizer. Access completion is detected on the synchronized rising edge of a strobe that was issued while the select was low. The CPU-side status shows three flags: input buffer full, output buffer full and input overflow.

The data pins are driven only while the raw read strobe and the raw select are both low in slave mode. The block presents the pins as a separate input, output and output-enable so that the pad ring can build the tri-state buffer.

Top module: `pslv_port`

## Requirements
- R1: After reset, the control location reads 0x07, the data location reads 0x00, `host_data_oe` is 0 and `dir_o` is 3'b111.
- R2: While the mode bit (control bit 4) is 0, host strobes change neither flag, do not load the input buffer and do not drive the pins.
- R3: In slave mode, `host_data_oe` is 1 exactly while `host_rd_n` and `host_cs_n` are both 0, and `host_data_o` then carries the output buffer.
- R4: In slave mode, the value on `host_data_i` while the synchronized write strobe and select are low is latched into the input buffer. The CPU reads it at address 0.
- R5: Input-buffer-full (control bit 7) is set when a host write completes, which is a synchronized rising write strobe with the select low. A CPU read of address 0 (`cpu_re`=1) clears it. Set wins over clear.
- R6: Input-overflow (control bit 5) is set when a host write completes while bit 7 is already 1. Only a CPU write to address 1 with bit 5 = 0 clears it. Writing 1 leaves it unchanged.
- R7: Output-buffer-full (control bit 6) is set when the CPU writes address 0. It is cleared when a host read completes, which is a synchronized rising read strobe with the select low.
- R8: CPU writes to address 1 load bit 4 and bits 2:0 (`dir_o`). Bits 7 and 6 ignore CPU writes, and bit 3 always reads 0.
- R9: With `host_cs_n` = 1, host strobes neither load data, nor change flags, nor drive the pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_cs_n | input | 1 | Host select, 0 = selected |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_wr_n | input | 1 | Host write strobe, active low |
| host_data_i | input | 8 | Value seen on the data pins |
| host_data_o | output | 8 | Value to drive on the data pins |
| host_data_oe | output | 1 | Pin driver enable |
| cpu_addr | input | 1 | 0 = data location, 1 = control/status location |
| cpu_we | input | 1 | CPU write strobe, one cycle |
| cpu_re | input | 1 | CPU read strobe (read side effects), one cycle |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | CPU read data for the addressed location |
| dir_o | output | 3 | General-purpose direction bits (control bits 2:0) |

## Verification
The embedded properties check on every cycle how completion events update the flags:
- a completed write always raises input-buffer-full;
- a completed write onto a full buffer raises overflow;
- overflow persists until an explicit clearing write;
- CPU data writes set output-buffer-full, and host reads clear it;
- mode is quiet.

The bench scenarios are needed to show the end-to-end values seen at the ports:
- the data that a host write leaves in the buffer;
- the pin drive window and its data;
- the read-only and reserved control bits;
- the ignoring of strobes while the select is high.

// File: rtl/pslv_pkg.sv
package pslv_pkg;

  localparam int unsigned DATA_W = 8;
  localparam int unsigned DIR_W  = 3;

  localparam logic ADDR_DATA = 1'b0;
  localparam logic ADDR_CTRL = 1'b1;

  // Bit order is the programmer-visible layout of the control location.
  typedef struct packed {
    logic             ibf;   // bit 7
    logic             obf;   // bit 6
    logic             ovf;   // bit 5
    logic             mode;  // bit 4
    logic             rsvd;  // bit 3
    logic [DIR_W-1:0] dir;   // bits 2:0
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{ibf: 1'b0, obf: 1'b0, ovf: 1'b0, mode: 1'b0,
                                 rsvd: 1'b0, dir: {DIR_W{1'b1}}};

endpackage

// File: rtl/pslv_sync.sv
module pslv_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2,
  parameter logic        RST_V  = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[i] <= {W{RST_V}};
          else        stg[i] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[i] <= {W{RST_V}};
          else        stg[i] <= stg[i-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];

endmodule

// File: rtl/pslv_edge.sv
module pslv_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic mode,
  input  logic cs_s,
  input  logic rd_s,
  input  logic wr_s,
  output logic wr_done,
  output logic rd_done,
  output logic wr_active
);

  logic cs_q, rd_q, wr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q <= 1'b1;
      rd_q <= 1'b1;
      wr_q <= 1'b1;
    end else begin
      cs_q <= cs_s;
      rd_q <= rd_s;
      wr_q <= wr_s;
    end
  end

  // Completion: strobe was low with select low in the previous cycle, high now.
  always_comb begin
    wr_done   = mode & ~wr_q & wr_s & ~cs_q;
    rd_done   = mode & ~rd_q & rd_s & ~cs_q;
    wr_active = mode & ~wr_s & ~cs_s;
  end

endmodule

// File: rtl/pslv_regs.sv
module pslv_regs
  import pslv_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_done,
  input  logic              rd_done,
  input  logic              wr_active,
  input  logic [DATA_W-1:0] host_data_i,
  input  logic              cpu_addr,
  input  logic              cpu_we,
  input  logic              cpu_re,
  input  logic [DATA_W-1:0] cpu_wdata,
  output ctrl_t             ctrl,
  output logic [DATA_W-1:0] in_buf,
  output logic [DATA_W-1:0] out_buf
);

  ctrl_t             ctrl_n;
  logic [DATA_W-1:0] in_buf_n, out_buf_n;
  logic              in_en, out_en;
  logic              cpu_wr_data, cpu_wr_ctrl, cpu_rd_data;

  always_comb begin
    cpu_wr_data = cpu_we & (cpu_addr == ADDR_DATA);
    cpu_wr_ctrl = cpu_we & (cpu_addr == ADDR_CTRL);
    cpu_rd_data = cpu_re & (cpu_addr == ADDR_DATA);

    ctrl_n = ctrl;
    if (cpu_wr_ctrl) begin
      ctrl_n.mode = cpu_wdata[4];
      ctrl_n.dir  = cpu_wdata[DIR_W-1:0];
      if (!cpu_wdata[5]) ctrl_n.ovf = 1'b0;
    end
    if (wr_done && ctrl.ibf) ctrl_n.ovf = 1'b1;
    if (cpu_rd_data)         ctrl_n.ibf = 1'b0;
    if (wr_done)             ctrl_n.ibf = 1'b1;
    if (rd_done)             ctrl_n.obf = 1'b0;
    if (cpu_wr_data)         ctrl_n.obf = 1'b1;
    ctrl_n.rsvd = 1'b0;

    in_en     = wr_active;
    in_buf_n  = host_data_i;
    out_en    = cpu_wr_data;
    out_buf_n = cpu_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl <= CTRL_RST;
    else        ctrl <= ctrl_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     in_buf <= '0;
    else if (in_en) in_buf <= in_buf_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      out_buf <= '0;
    else if (out_en) out_buf <= out_buf_n;
  end

  p_ibf_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |=> ctrl.ibf);

  p_ovf_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_done && ctrl.ibf) |=> ctrl.ovf);

  p_ovf_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.ovf && !(cpu_wr_ctrl && !cpu_wdata[5])) |=> ctrl.ovf);

  p_obf_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr_data |=> ctrl.obf);

  p_obf_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_done && !cpu_wr_data) |=> !ctrl.obf);

  p_mode_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr_ctrl |=> ctrl.mode == $past(cpu_wdata[4]));

endmodule

// File: rtl/pslv_port.sv
module pslv_port
  import pslv_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_cs_n,
  input  logic              host_rd_n,
  input  logic              host_wr_n,
  input  logic [DATA_W-1:0] host_data_i,
  output logic [DATA_W-1:0] host_data_o,
  output logic              host_data_oe,
  input  logic              cpu_addr,
  input  logic              cpu_we,
  input  logic              cpu_re,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic [DIR_W-1:0]  dir_o
);

  logic [2:0]        strb_s;
  logic              wr_done, rd_done, wr_active;
  ctrl_t             ctrl;
  logic [DATA_W-1:0] in_buf, out_buf;

  pslv_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_V(1'b1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({host_cs_n, host_rd_n, host_wr_n}),
    .q     (strb_s)
  );

  pslv_edge u_edge (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (ctrl.mode),
    .cs_s      (strb_s[2]),
    .rd_s      (strb_s[1]),
    .wr_s      (strb_s[0]),
    .wr_done   (wr_done),
    .rd_done   (rd_done),
    .wr_active (wr_active)
  );

  pslv_regs u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_done     (wr_done),
    .rd_done     (rd_done),
    .wr_active   (wr_active),
    .host_data_i (host_data_i),
    .cpu_addr    (cpu_addr),
    .cpu_we      (cpu_we),
    .cpu_re      (cpu_re),
    .cpu_wdata   (cpu_wdata),
    .ctrl        (ctrl),
    .in_buf      (in_buf),
    .out_buf     (out_buf)
  );

  always_comb begin
    host_data_o  = out_buf;
    host_data_oe = ctrl.mode & ~host_rd_n & ~host_cs_n;
    cpu_rdata    = (cpu_addr == ADDR_CTRL) ? DATA_W'(ctrl) : in_buf;
    dir_o        = ctrl.dir;
  end

  p_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.mode |-> (!wr_done && !rd_done && !wr_active));

  p_noevt_cs_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (strb_s[2] && $past(strb_s[2])) |-> (!wr_done && !rd_done && !wr_active));

  p_drive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    host_data_oe |-> (!host_cs_n && ctrl.mode));

endmodule

// File: tb/pslv_port_tb.sv
module pslv_port_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       host_cs_n, host_rd_n, host_wr_n;
  logic [7:0] host_data_i, host_data_o;
  logic       host_data_oe;
  logic       cpu_addr, cpu_we, cpu_re;
  logic [7:0] cpu_wdata, cpu_rdata;
  logic [2:0] dir_o;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;  // 250 MHz

  pslv_port u_dut (
    .clk(clk), .rst_n(rst_n),
    .host_cs_n(host_cs_n), .host_rd_n(host_rd_n), .host_wr_n(host_wr_n),
    .host_data_i(host_data_i), .host_data_o(host_data_o), .host_data_oe(host_data_oe),
    .cpu_addr(cpu_addr), .cpu_we(cpu_we), .cpu_re(cpu_re),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .dir_o(dir_o)
  );

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%02h expected=%02h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cpu_write(input logic a, input logic [7:0] v);
    @(negedge clk);
    cpu_addr = a; cpu_we = 1'b1; cpu_wdata = v;
    @(negedge clk);
    cpu_we = 1'b0;
  endtask

  task automatic cpu_peek(input logic a, output logic [7:0] v);
    @(negedge clk);
    cpu_addr = a;
    #1 v = cpu_rdata;
  endtask

  task automatic cpu_take(output logic [7:0] v);
    @(negedge clk);
    cpu_addr = 1'b0; cpu_re = 1'b1;
    #1 v = cpu_rdata;
    @(negedge clk);
    cpu_re = 1'b0;
  endtask

  task automatic host_write(input logic cs, input logic [7:0] v);
    @(negedge clk);
    host_data_i = v; host_cs_n = cs; host_wr_n = 1'b0;
    cycles(4);
    host_wr_n = 1'b1; host_cs_n = 1'b1;
    cycles(5);
    host_data_i = 8'h00;
    cycles(1);
  endtask

  task automatic host_read(input string req, input logic cs, input logic exp_oe, input logic [7:0] exp_d);
    @(negedge clk);
    host_cs_n = cs; host_rd_n = 1'b0;
    #1;
    chk(req, "pin drive during read", {7'd0, host_data_oe}, {7'd0, exp_oe});
    if (exp_oe) chk(req, "pin data during read", host_data_o, exp_d);
    cycles(4);
    host_rd_n = 1'b1; host_cs_n = 1'b1;
    #1;
    chk(req, "pin drive after read", {7'd0, host_data_oe}, 8'h00);
    cycles(5);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    cpu_peek(1'b1, v); chk("R1", "ctrl after reset", v, 8'h07);
    cpu_peek(1'b0, v); chk("R1", "data after reset", v, 8'h00);
    chk("R1", "dir after reset", {5'd0, dir_o}, 8'h07);
    chk("R1", "oe after reset", {7'd0, host_data_oe}, 8'h00);
  endtask

  task automatic t_ctrl_bits();
    logic [7:0] v;
    cpu_write(1'b1, 8'hFF);
    cpu_peek(1'b1, v); chk("R8", "ctrl after writing FF", v, 8'h17);
    cpu_write(1'b1, 8'h12);
    cpu_peek(1'b1, v); chk("R8", "ctrl after writing 12", v, 8'h12);
    chk("R8", "dir after writing 12", {5'd0, dir_o}, 8'h02);
  endtask

  task automatic t_mode_off();
    logic [7:0] v;
    cpu_write(1'b1, 8'h07);
    host_write(1'b0, 8'hA5);
    cpu_peek(1'b1, v); chk("R2", "ctrl after host write in port mode", v, 8'h07);
    cpu_peek(1'b0, v); chk("R2", "data after host write in port mode", v, 8'h00);
    host_read("R2", 1'b0, 1'b0, 8'h00);
  endtask

  task automatic t_host_write();
    logic [7:0] v;
    cpu_write(1'b1, 8'h17);
    host_write(1'b0, 8'h3C);
    cpu_peek(1'b1, v); chk("R5", "ibf after host write", v, 8'h97);
    cpu_take(v);       chk("R4", "data latched from pins", v, 8'h3C);
    cpu_peek(1'b1, v); chk("R5", "ibf after cpu read", v, 8'h17);
  endtask

  task automatic t_overflow();
    logic [7:0] v;
    host_write(1'b0, 8'h11);
    host_write(1'b0, 8'h22);
    cpu_peek(1'b1, v); chk("R6", "overflow after second write", v, 8'hB7);
    cpu_take(v);       chk("R4", "latest data kept", v, 8'h22);
    cpu_peek(1'b1, v); chk("R6", "overflow survives data read", v, 8'h37);
    cpu_write(1'b1, 8'h37);
    cpu_peek(1'b1, v); chk("R6", "overflow survives writing 1", v, 8'h37);
    cpu_write(1'b1, 8'h17);
    cpu_peek(1'b1, v); chk("R6", "overflow cleared by writing 0", v, 8'h17);
  endtask

  task automatic t_host_read();
    logic [7:0] v;
    cpu_write(1'b0, 8'h5A);
    cpu_peek(1'b1, v); chk("R7", "obf after cpu write", v, 8'h57);
    host_read("R3", 1'b0, 1'b1, 8'h5A);
    cpu_peek(1'b1, v); chk("R7", "obf after host read", v, 8'h17);
  endtask

  task automatic t_cs_high();
    logic [7:0] v;
    host_write(1'b1, 8'h99);
    cpu_peek(1'b1, v); chk("R9", "ctrl after deselected write", v, 8'h17);
    cpu_peek(1'b0, v); chk("R9", "data after deselected write", v, 8'h22);
    cpu_write(1'b0, 8'h66);
    host_read("R9", 1'b1, 1'b0, 8'h00);
    cpu_peek(1'b1, v); chk("R9", "obf after deselected read", v, 8'h57);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    host_cs_n = 1'b1; host_rd_n = 1'b1; host_wr_n = 1'b1; host_data_i = 8'h00;
    cpu_addr = 1'b0; cpu_we = 1'b0; cpu_re = 1'b0; cpu_wdata = 8'h00;
    cycles(3);
    rst_n = 1'b1;
    cycles(2);
    t_reset();
    t_ctrl_bits();
    t_mode_off();
    t_host_write();
    t_overflow();
    t_host_read();
    t_cs_high();
    summary();
    $finish;
  end

endmodule